// File: doc/BRIEF.md
# Banked GPIO Expander Register File

This block is the register core of an I/O port expander with up to eight 8-bit ports. A host reaches it through a plain parallel register bus: an address, write data, a write strobe, a read strobe and a registered read-data return. Each port has three registers that are always directly addressable: a sampled input value, an output latch, and a latched change-status byte. A second group of per-port settings sits behind a port-select pointer. These are the interrupt mask, the PWM routing, the input inversion, the direction, and seven drive modes. A single address window reaches whichever port the pointer names.

The block drives per-pin output level, direction, PWM-select and one-hot drive-mode vectors toward the pad ring. It samples the pins through a two-flop synchronizer and raises a level interrupt while any unmasked pin change is still unread. The pin count of the variant is a parameter (20, 40 or 60). Ports and bit positions beyond the variant, and the upper half of port 2, read as zero, ignore writes and drive zero. Read data returns one cycle after the read strobe. The bus has no back-pressure: every access completes in a single cycle, so the host never waits.

Top module: `gpx_regfile`

## Requirements
- R1: After reset the output latches hold 1 on every implemented bit, the port pointer is 0, PWM routing, inversion and direction are 0, the interrupt mask is all ones, and pull-up is the selected drive mode of every implemented pin.
- R2: Address 0x08+p reads and writes the output latch of port p, and the latch drives pin_out[8p+7:8p] from the cycle after the write.
- R3: Address 0x00+p returns the synchronized pin value of port p XORed with its inversion bits, updated three clock edges after a pin change; writes there have no effect.
- R4: Address 0x18 holds the port pointer in its low three bits; the upper five bits are dropped on write and read back as 0.
- R5: Addresses 0x19 (interrupt mask), 0x1A (PWM routing to pin_pwm), 0x1B (inversion) and 0x1C (direction to pin_dir, 1 = input, 0 = output) access only the copy of the port named by the pointer.
- R6: Addresses 0x1D to 0x23 are the drive modes, in the order pull-up, pull-down, open-drain-high, open-drain-low, strong-fast, strong-slow, high-Z (mode index m = address − 0x1D). Writing 1 to a bit selects that mode for the pin and clears the bit in the other six modes of that port. Writing 0 changes nothing. Mode m of pin b appears on pin_drive[64m+b].
- R7: Bits 20 to 23 (the upper nibble of port 2), and every bit at or above pin count + 4, are unimplemented: they read 0, ignore writes and drive 0 on every pin output.
- R8: A status bit of port p is set when the synchronized value of that pin changes while its mask bit is 0; a masked pin never sets it.
- R9: Reading 0x10+p returns the status byte of port p and clears it. A status bit being set in the same cycle as the read stays set.
- R10: irq is high exactly while any status bit is set.
- R11: Address 0x2E returns the identity byte: the upper nibble is pin count / 10, and the lower nibble is the REVISION parameter.
- R12: Addresses 0x24 to 0x2D, 0x2F and everything from 0x30 upward read 0 and ignore writes.
- R13: bus_rdata is loaded at the clock edge that samples bus_rd and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| pin_in | input | 64 | Raw pin levels, port p at [8p+7:8p] |
| pin_out | output | 64 | Output level per pin |
| pin_dir | output | 64 | Direction per pin, 1 = input |
| pin_pwm | output | 64 | PWM routing select per pin |
| pin_drive | output | 448 | One-hot drive mode per pin, mode m at [64m+63:64m] |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The assertions assume that the strobes and address are two-state and never unknown. They also assume that bus_wr and bus_rd are not raised together, so that a write to a latch and a read of it never share a cycle. The bench drives every bus access from a task on the falling clock edge and holds each strobe for exactly one cycle. It never overlaps a read with a write. Pin levels change only on the falling edge, so the three-edge sampling path and the read-versus-set collision on a status bit can be placed on a chosen clock edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BANK_W    = 8;
  localparam int MAX_PORTS = 8;
  localparam int VEC_W     = BANK_W * MAX_PORTS;
  localparam int NUM_MODES = 7;
  localparam int GAP_LO    = 20;
  localparam int GAP_W     = 4;

  // directly addressed windows: address[7:3] selects the window, [2:0] the port
  localparam logic [4:0] WIN_IN   = 5'h00;
  localparam logic [4:0] WIN_OUT  = 5'h01;
  localparam logic [4:0] WIN_STS  = 5'h02;

  localparam logic [7:0] A_PSEL     = 8'h18;
  localparam logic [7:0] A_BANK_LO  = 8'h19;
  localparam logic [7:0] A_BANK_HI  = 8'h23;
  localparam logic [7:0] A_IDENT    = 8'h2E;

  // offsets inside the banked window
  localparam logic [3:0] IDX_MASK = 4'd0;
  localparam logic [3:0] IDX_PWM  = 4'd1;
  localparam logic [3:0] IDX_INV  = 4'd2;
  localparam logic [3:0] IDX_DIR  = 4'd3;
  localparam logic [3:0] IDX_DRV0 = 4'd4;

  typedef enum logic [2:0] {
    DRV_PULLUP, DRV_PULLDN, DRV_OD_HI, DRV_OD_LO, DRV_FAST, DRV_SLOW, DRV_HIZ
  } drv_mode_e;

  // bits that exist for a variant: the nibble gap in port 2 is skipped
  function automatic logic [VEC_W-1:0] impl_mask(input int pins);
    logic [VEC_W-1:0] m;
    m = '0;
    for (int b = 0; b < VEC_W; b++) begin
      if (!(b >= GAP_LO && b < GAP_LO + GAP_W) && b < pins + GAP_W) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/gpx_pin_sampler.sv
module gpx_pin_sampler #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] invert_i,
  output logic [W-1:0] value_o,
  output logic [W-1:0] change_o
);
  logic [W-1:0] meta_q, sync_q, prev_q, val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      val_q  <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      val_q  <= sync_q ^ invert_i;
    end
  end

  assign value_o  = val_q;
  assign change_o = sync_q ^ prev_q;
endmodule

// File: rtl/gpx_cfg_bank.sv
module gpx_cfg_bank
  import gpx_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [3:0]                  wr_idx,
  input  logic [W-1:0]                wdata,
  output logic [W-1:0]                mask_o,
  output logic [W-1:0]                pwm_o,
  output logic [W-1:0]                inv_o,
  output logic [W-1:0]                dir_o,
  output logic [NUM_MODES-1:0][W-1:0] drv_o
);
  logic [W-1:0]                mask_q, pwm_q, inv_q, dir_q;
  logic [NUM_MODES-1:0][W-1:0] drv_q;
  logic [W-1:0]                wd;

  assign wd = wdata & IMPL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= IMPL;
      pwm_q  <= '0;
      inv_q  <= '0;
      dir_q  <= '0;
      for (int m = 0; m < NUM_MODES; m++) begin
        drv_q[m] <= (m == int'(DRV_PULLUP)) ? IMPL : '0;
      end
    end else if (wr_en) begin
      case (wr_idx)
        IDX_MASK: mask_q <= wd;
        IDX_PWM:  pwm_q  <= wd;
        IDX_INV:  inv_q  <= wd;
        IDX_DIR:  dir_q  <= wd;
        default: begin
          // selecting a mode for a pin removes it from every other mode
          for (int m = 0; m < NUM_MODES; m++) begin
            if (wr_idx == 4'(int'(IDX_DRV0) + m)) drv_q[m] <= drv_q[m] | wd;
            else                                  drv_q[m] <= drv_q[m] & ~wd;
          end
        end
      endcase
    end
  end

  assign mask_o = mask_q;
  assign pwm_o  = pwm_q;
  assign inv_o  = inv_q;
  assign dir_o  = dir_q;
  assign drv_o  = drv_q;
endmodule

// File: rtl/gpx_irq_latch.sv
module gpx_irq_latch #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;

  // a new event outranks the clear of a read in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_i) | set_i;
  end

  assign status_o = status_q;
  assign irq_o    = |status_q;
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int         PIN_COUNT = 60,
  parameter logic [3:0] REVISION  = 4'h0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 bus_addr,
  input  logic [7:0]                 bus_wdata,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  output logic [7:0]                 bus_rdata,
  input  logic [VEC_W-1:0]           pin_in,
  output logic [VEC_W-1:0]           pin_out,
  output logic [VEC_W-1:0]           pin_dir,
  output logic [VEC_W-1:0]           pin_pwm,
  output logic [NUM_MODES*VEC_W-1:0] pin_drive,
  output logic                       irq
);
  localparam logic [VEC_W-1:0] IMPL    = impl_mask(PIN_COUNT);
  localparam logic [7:0]       ID_BYTE = {4'(PIN_COUNT / 10), REVISION};

  // ---------------- decode ----------------
  logic [2:0] a_port;
  logic       in_hit, out_hit, sts_hit, psel_hit, bank_hit, id_hit;
  logic [3:0] bank_idx;
  logic [2:0] mode_idx;

  assign a_port   = bus_addr[2:0];
  assign in_hit   = bus_addr[7:3] == WIN_IN;
  assign out_hit  = bus_addr[7:3] == WIN_OUT;
  assign sts_hit  = bus_addr[7:3] == WIN_STS;
  assign psel_hit = bus_addr == A_PSEL;
  assign bank_hit = bus_addr >= A_BANK_LO && bus_addr <= A_BANK_HI;
  assign id_hit   = bus_addr == A_IDENT;
  assign bank_idx = 4'(bus_addr - A_BANK_LO);
  assign mode_idx = 3'(bank_idx - IDX_DRV0);

  // ---------------- port pointer and output latches ----------------
  logic [2:0]       port_sel_q;
  logic [VEC_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_sel_q <= '0;
      out_q      <= IMPL;
    end else if (bus_wr) begin
      if (psel_hit) port_sel_q <= bus_wdata[2:0];
      if (out_hit)
        out_q[a_port*BANK_W +: BANK_W] <= bus_wdata & IMPL[a_port*BANK_W +: BANK_W];
    end
  end

  // ---------------- banked configuration ----------------
  logic [MAX_PORTS-1:0][BANK_W-1:0]                mask_b, pwm_b, inv_b, dir_b;
  logic [MAX_PORTS-1:0][NUM_MODES-1:0][BANK_W-1:0] drv_b;
  logic                                            bank_wr;

  assign bank_wr = bus_wr && bank_hit;

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_bank
    gpx_cfg_bank #(
      .W    (BANK_W),
      .IMPL (IMPL[p*BANK_W +: BANK_W])
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr && port_sel_q == 3'(p)),
      .wr_idx (bank_idx),
      .wdata  (bus_wdata),
      .mask_o (mask_b[p]),
      .pwm_o  (pwm_b[p]),
      .inv_o  (inv_b[p]),
      .dir_o  (dir_b[p]),
      .drv_o  (drv_b[p])
    );
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      assign pin_drive[m*VEC_W + p*BANK_W +: BANK_W] = drv_b[p][m];
    end
  end

  // ---------------- sampling and change status ----------------
  logic [VEC_W-1:0] in_val, in_chg, sts_vec, sts_set, sts_clr;

  gpx_pin_sampler #(.W(VEC_W)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_in),
    .invert_i (inv_b),
    .value_o  (in_val),
    .change_o (in_chg)
  );

  assign sts_set = in_chg & ~mask_b & IMPL;

  always_comb begin
    sts_clr = '0;
    if (bus_rd && sts_hit) sts_clr[a_port*BANK_W +: BANK_W] = '1;
  end

  gpx_irq_latch #(.W(VEC_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (sts_set),
    .clr_i    (sts_clr),
    .status_o (sts_vec),
    .irq_o    (irq)
  );

  // ---------------- read path ----------------
  logic [VEC_W-1:0] in_masked;
  logic [7:0]       rd_next;

  assign in_masked = in_val & IMPL;

  always_comb begin
    rd_next = '0;
    if (in_hit)        rd_next = in_masked[a_port*BANK_W +: BANK_W];
    else if (out_hit)  rd_next = out_q[a_port*BANK_W +: BANK_W];
    else if (sts_hit)  rd_next = sts_vec[a_port*BANK_W +: BANK_W];
    else if (psel_hit) rd_next = {5'b0, port_sel_q};
    else if (id_hit)   rd_next = ID_BYTE;
    else if (bank_hit) begin
      case (bank_idx)
        IDX_MASK: rd_next = mask_b[port_sel_q];
        IDX_PWM:  rd_next = pwm_b[port_sel_q];
        IDX_INV:  rd_next = inv_b[port_sel_q];
        IDX_DIR:  rd_next = dir_b[port_sel_q];
        default:  if (int'(mode_idx) < NUM_MODES) rd_next = drv_b[port_sel_q][mode_idx];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  assign pin_out = out_q;
  assign pin_dir = dir_b;
  assign pin_pwm = pwm_b;
endmodule

// File: rtl/gpx_regfile_chk.sv
module gpx_regfile_chk
  import gpx_pkg::*;
#(
  parameter int PIN_COUNT = 60
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [7:0]                 bus_addr,
  input logic [7:0]                 bus_wdata,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [7:0]                 bus_rdata,
  input logic [VEC_W-1:0]           pin_out,
  input logic [VEC_W-1:0]           pin_dir,
  input logic [VEC_W-1:0]           pin_pwm,
  input logic [NUM_MODES*VEC_W-1:0] pin_drive
);
  localparam logic [VEC_W-1:0] IMPL = impl_mask(PIN_COUNT);

  logic drv_bad;
  always_comb begin
    drv_bad = 1'b0;
    for (int b = 0; b < VEC_W; b++) begin
      int cnt;
      cnt = 0;
      for (int m = 0; m < NUM_MODES; m++) cnt += int'(pin_drive[m*VEC_W + b]);
      if (IMPL[b] && cnt != 1) drv_bad = 1'b1;
    end
  end

  logic unmapped;
  assign unmapped = bus_addr > A_BANK_HI && bus_addr != A_IDENT;

  // R6
  drive_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) !drv_bad);

  // R7
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out | pin_dir | pin_pwm) & ~IMPL) == '0);

  // R2
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[7:3] == WIN_OUT) |=>
      pin_out[$past(bus_addr[2:0])*BANK_W +: BANK_W] ==
        ($past(bus_wdata) & IMPL[$past(bus_addr[2:0])*BANK_W +: BANK_W]));

  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> bus_rdata == 8'h00);

  // R5
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_pwm) && $stable(pin_dir));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpx_regfile gpx_regfile_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (.*);

// File: tb/gpx_regfile_tb.sv
module gpx_regfile_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   bus_addr = '0, bus_wdata = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_rdata;
  logic [63:0]  pin_in = '0;
  logic [63:0]  pin_out, pin_dir, pin_pwm;
  logic [447:0] pin_drive;
  logic         irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpx_regfile u_dut (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
    .pin_in, .pin_out, .pin_dir, .pin_pwm, .pin_drive, .irq
  );

  // scoreboard of expected read data
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R13 unexpected read data actual=%02h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] drv(input int m, input int p);
    return pin_drive[m*64 + p*8 +: 8];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pin_out == 64'hFFFF_FFFF_FF0F_FFFF, "R1 pin_out reset", pin_out, 64'hFFFF_FFFF_FF0F_FFFF);
    chk(pin_dir == 64'h0 && pin_pwm == 64'h0, "R1 dir/pwm reset", pin_dir | pin_pwm, 64'h0);
    chk(drv(0, 1) == 8'hFF, "R1 pull-up reset", 64'(drv(0, 1)), 64'hFF);
    chk(irq == 1'b0, "R10 irq reset", 64'(irq), 64'h0);
    rd(8'h08, 8'hFF, "R1 out0 reset");
    rd(8'h18, 8'h00, "R1 psel reset");
    rd(8'h1A, 8'h00, "R1 pwm reset");
    rd(8'h19, 8'hFF, "R1 mask reset");

    // R2 output latches
    wr(8'h09, 8'hA5);
    chk(pin_out[15:8] == 8'hA5, "R2 pin_out port1", 64'(pin_out[15:8]), 64'hA5);
    rd(8'h09, 8'hA5, "R2 out1 readback");

    // R7 port-2 nibble gap
    rd(8'h0A, 8'h0F, "R7 out2 reset");
    wr(8'h0A, 8'hA5);
    chk(pin_out[23:16] == 8'h05, "R7 pin_out port2", 64'(pin_out[23:16]), 64'h05);
    pin_in[23:16] = 8'hFF;
    repeat (4) @(negedge clk);
    rd(8'h02, 8'h0F, "R7 in2 upper nibble");

    // R4 port pointer
    wr(8'h18, 8'hF9);
    rd(8'h18, 8'h01, "R4 psel upper bits dropped");

    // R5 banked direction
    wr(8'h18, 8'h03); wr(8'h1C, 8'h3C);
    wr(8'h18, 8'h05); wr(8'h1C, 8'hC3);
    wr(8'h18, 8'h03);
    rd(8'h1C, 8'h3C, "R5 dir port3");
    chk(pin_dir[31:24] == 8'h3C && pin_dir[47:40] == 8'hC3, "R5 pin_dir ports3/5",
        64'({pin_dir[47:40], pin_dir[31:24]}), 64'hC33C);
    wr(8'h18, 8'h06); wr(8'h1A, 8'h81);
    chk(pin_pwm[55:48] == 8'h81 && pin_pwm[47:0] == 48'h0, "R5 pin_pwm port6",
        pin_pwm, 64'h0081_0000_0000_0000);

    // R6 drive modes on port 1
    wr(8'h18, 8'h01);
    wr(8'h21, 8'h0F);
    rd(8'h1D, 8'hF0, "R6 pull-up cleared by fast");
    rd(8'h21, 8'h0F, "R6 fast set");
    wr(8'h1D, 8'h00);
    rd(8'h1D, 8'hF0, "R6 zero write no effect");
    wr(8'h20, 8'h81);
    rd(8'h1D, 8'h70, "R6 pull-up after od-low");
    rd(8'h21, 8'h0E, "R6 fast after od-low");
    chk(drv(3, 1) == 8'h81 && drv(4, 1) == 8'h0E && drv(0, 1) == 8'h70, "R6 pin_drive port1",
        64'({drv(0, 1), drv(3, 1), drv(4, 1)}), 64'h70810E);

    // R3 input sampling and inversion on port 4
    pin_in[39:32] = 8'h5A;
    repeat (4) @(negedge clk);
    rd(8'h04, 8'h5A, "R3 input port4");
    wr(8'h18, 8'h04); wr(8'h1B, 8'hFF);
    repeat (2) @(negedge clk);
    rd(8'h04, 8'hA5, "R3 inverted input");
    wr(8'h04, 8'h00);
    rd(8'h04, 8'hA5, "R3 input write ignored");
    rd(8'h14, 8'h00, "R8 masked changes not latched");

    // R8/R9/R10 status
    wr(8'h19, 8'hFE);
    pin_in[33] = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq == 1'b0, "R8 masked pin no irq", 64'(irq), 64'h0);
    pin_in[32] = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R10 irq raised", 64'(irq), 64'h1);
    rd(8'h14, 8'h01, "R8 status latched");
    chk(irq == 1'b0, "R9 irq cleared by read", 64'(irq), 64'h0);
    rd(8'h14, 8'h00, "R9 status cleared");

    // R9 read and set on the same edge
    pin_in[32] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rd(8'h14, 8'h00, "R9 collision read");
    chk(irq == 1'b1, "R9 set survives read", 64'(irq), 64'h1);
    rd(8'h14, 8'h01, "R9 collision bit kept");

    // R12 unmapped, R11 identity, R13 hold
    rd(8'h25, 8'h00, "R12 gap read");
    wr(8'h26, 8'h5A);
    rd(8'h26, 8'h00, "R12 write ignored");
    rd(8'h30, 8'h00, "R12 upper read");
    rd(8'h2E, 8'h60, "R11 identity");
    repeat (3) @(negedge clk);
    chk(bus_rdata == 8'h60, "R13 rdata held", 64'(bus_rdata), 64'h60);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule